// File: doc/BRIEF.md
# Dithered Digital PWM Generator

This block turns a duty command into one pulse per switching period for a switching power converter controller. The command splits into two halves. The upper half is a coarse width, counted in clock slots from the start of the period. A period holds 32 slots, standing in for the taps of a delay line. The lower half is a fine value. It is spread over successive periods by adding one slot to the pulse in some periods and not in others. Averaged over 32 periods, the duty then reaches the full resolution of the command.

A period begins on a period-start strobe from the controller. On that clock edge the command is captured, and the generator decides whether this period gets the extra slot. It also raises a one-cycle marker. The command is held until the next strobe, so a change in the middle of a pulse never changes that pulse. A period lengthened by the extra slot is picked by comparing the bit-reversed period index with the fine value. This spreads the lengthened periods evenly across each 32-period window instead of grouping them. Fine resolution only pays off if its step is smaller than the step of the converter's sensing path. That is what keeps the loop free of limit cycles in steady state.

Top module: `dpwm_dither`

## Requirements
- R1: After reset, `pwm_out` and `period_mark` stay low until the first `period_start` is taken.
- R2: `period_mark` is high for exactly the one cycle after each clock edge at which `period_start` is high, and low otherwise.
- R3: `duty_cmd` is captured only on a clock edge with `period_start` high; changes at any other time have no effect on the pulse under way.
- R4: With `duty_cmd` not all ones, `pwm_out` rises in the cycle after the strobe edge and stays high for W consecutive cycles. W is `duty_cmd[9:5]` plus one when the period is extended, and W is `duty_cmd[9:5]` otherwise.
- R5: Over any 32 consecutive periods with a constant command, the number of extended periods equals `duty_cmd[4:0]`.
- R6: Periods are numbered from 0, counting strobes taken since reset. Period k is extended when the 5-bit reversal of (k mod 32) is less than `duty_cmd[4:0]`. As a result, a fine value of 16 or less never extends two periods in a row.
- R7: A command of zero gives no pulse at all.
- R8: A command of all ones (1023) holds `pwm_out` high for the whole period, up to the next strobe edge, however long the period lasts.
- R9: For commands other than all ones, `pwm_out` is low from slot 32 of a period until the next strobe.
- R10: A strobe that arrives before the pulse has ended starts a new period at once, with a new capture and a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_start | input | 1 | Starts a switching period on the edge where it is high |
| duty_cmd | input | 10 | Duty command: bits 9:5 coarse, bits 4:0 fine |
| pwm_out | output | 1 | Pulse-width modulated output |
| period_mark | output | 1 | One-cycle marker after each period start |

## Verification
Assertions check on every cycle that the marker follows each strobe and only each strobe, and that the held command does not move between strobes. They also check that a zero command stays quiet, that an all-ones command stays high, and that the output is low once the slot counter reaches its end. Only the bench can show properties that span whole periods or windows of periods. These are the exact pulse width, the order of extended periods across a 32-period window, and the total number of extensions in that window. The bench also shows that a command changed in the middle of a pulse is ignored, and that an early strobe cuts the period short.

// File: rtl/dpwm_dither.sv
module dpwm_dither #(
  parameter int CW = 5,
  parameter int FW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          period_start,
  input  logic [CW+FW-1:0] duty_cmd,
  output logic          pwm_out,
  output logic          period_mark
);

  localparam int DW    = CW + FW;
  localparam int SLOTS = 1 << CW;

  logic [DW-1:0] duty_q;
  logic [CW:0]   slot_q;
  logic [FW-1:0] phase_q;
  logic [FW-1:0] phase_rev;
  logic          ext_q;
  logic          mark_q;
  logic          full_on;
  logic [CW:0]   width;

  always_comb begin
    for (int i = 0; i < FW; i++) phase_rev[i] = phase_q[FW-1-i];
  end

  assign full_on = &duty_q;
  assign width   = {1'b0, duty_q[DW-1:FW]} + {{CW{1'b0}}, ext_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q  <= '0;
      slot_q  <= (CW+1)'(SLOTS);
      phase_q <= '0;
      ext_q   <= 1'b0;
      mark_q  <= 1'b0;
    end else begin
      mark_q <= period_start;
      if (period_start) begin
        duty_q  <= duty_cmd;
        slot_q  <= '0;
        phase_q <= phase_q + 1'b1;
        ext_q   <= phase_rev < duty_cmd[FW-1:0];
      end else if (slot_q != (CW+1)'(SLOTS)) begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign pwm_out     = full_on | (slot_q < width);
  assign period_mark = mark_q;

  assert_mark_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> period_mark);
  assert_mark_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> !period_mark);
  assert_hold_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> $stable(duty_q));
  assert_ext_needs_fine_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q |-> (duty_q[FW-1:0] != '0));
  assert_zero_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> !pwm_out);
  assert_full_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&duty_q) |-> pwm_out);
  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == (CW+1)'(SLOTS) && !(&duty_q)) |-> !pwm_out);

endmodule

// File: tb/dpwm_dither_test.sv
module dpwm_dither_test;
  logic clk = 0;
  logic rst_n = 0;
  logic period_start = 0;
  logic [9:0] duty_cmd = '0;
  logic pwm_out, period_mark;

  int checks = 0;
  int fails = 0;
  int kper = 0;
  int last_high = 0;
  bit last_ext = 0;

  dpwm_dither uut (.clk(clk), .rst_n(rst_n), .period_start(period_start),
                   .duty_cmd(duty_cmd), .pwm_out(pwm_out), .period_mark(period_mark));

  always #4 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit ext_for(int k, int fine);
    logic [4:0] p, r;
    p = 5'(k % 32);
    for (int i = 0; i < 5; i++) r[i] = p[4-i];
    return int'(r) < fine;
  endfunction

  // one period of len cycles; optional mid-period command change at cycle chg
  task automatic run_period(input logic [9:0] d, input int len, input int chg, input logic [9:0] d2);
    int highs = 0, marks = 0, expw;
    bit contiguous = 1, seen_low = 0;
    last_ext = ext_for(kper, int'(d[4:0]));
    expw = (d == 10'h3FF) ? len : int'(d[9:5]) + int'(last_ext);
    if (expw > len) expw = len;
    duty_cmd = d;
    period_start = 1;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      period_start = 0;
      if (c == chg) duty_cmd = d2;
      if (pwm_out) begin highs++; if (seen_low) contiguous = 0; end
      else seen_low = 1;
      if (period_mark) marks += (c == 0) ? 1 : 100;
    end
    kper++;
    last_high = highs;
    check("R2 marker once at period start", marks, 1);
    check("R4 width", highs, expw);
    check("R4 contiguous pulse", int'(contiguous), 1);
  endtask

  task automatic t_reset;
    int bad = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pwm_out || period_mark) bad++;
    end
    check("R1 quiet after reset", bad, 0);
  endtask

  task automatic t_coarse;
    run_period({5'd5, 5'd0}, 40, -1, '0);
    check("R4 coarse 5", last_high, 5);
    run_period({5'd17, 5'd0}, 40, -1, '0);
    check("R4 coarse 17", last_high, 17);
  endtask

  task automatic t_dither;
    int next = 0, adj = 0;
    bit prev = 0;
    for (int p = 0; p < 32; p++) begin
      run_period({5'd7, 5'd11}, 36, -1, '0);
      check("R6 extension order", last_high, 7 + int'(last_ext));
      if (last_high == 8) begin next++; if (prev) adj++; end
      prev = (last_high == 8);
    end
    check("R5 extensions in window", next, 11);
    check("R6 no adjacent extensions", adj, 0);
  endtask

  task automatic t_zero;
    run_period(10'd0, 40, -1, '0);
    check("R7 zero command", last_high, 0);
  endtask

  task automatic t_full;
    run_period(10'h3FF, 45, -1, '0);
    check("R8 full on", last_high, 45);
  endtask

  task automatic t_hold;
    run_period({5'd20, 5'd0}, 40, 4, {5'd3, 5'd0});
    check("R3 mid-period change ignored", last_high, 20);
  endtask

  task automatic t_idle;
    run_period({5'd31, 5'd0}, 40, -1, '0);
    check("R9 low after slot 31", last_high, 31);
  endtask

  task automatic t_restart;
    run_period({5'd25, 5'd0}, 10, -1, '0);
    check("R10 cut period all high", last_high, 10);
    run_period({5'd6, 5'd0}, 36, -1, '0);
    check("R10 new period after early strobe", last_high, 6);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_coarse();
        t_dither();
        t_zero();
        t_full();
        t_hold();
        t_idle();
        t_restart();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule